// File: doc/BRIEF.md
# Overlapping Pulse-Shape Waveform Synthesizer

This block produces the digital amplitude samples that feed a T1/E1-style line driver. Software loads a signed pulse shape that covers three unit intervals (UI1, UI2, UI3), with fourteen programmable slots in each. Only the first twelve slots of each interval are played. A phase-step enable moves the block through the twelve phases of a unit interval. At the first phase of every interval it takes one symbol from the symbol input: a mark or a space.

Each output sample is the phase-by-phase sum of up to three contributions: UI1 of the current symbol, UI2 of the symbol before it, and UI3 of the symbol two back. The sum is formed in wide signed arithmetic and then clipped to the 7-bit two's-complement range. Marks alternate in polarity. A space contributes nothing. Any clip sets a sticky overflow flag, and a status read strobe clears it.

Shape writes land in a shadow bank. The whole shadow bank is copied into the active bank at the next unit-interval boundary, so a sample is never built from a half-updated shape. The sequencer has two named states. ST_IDLE is the state after reset. The first phase step takes it to ST_RUN (transition IDLE_TO_RUN), and that step is a unit-interval boundary. ST_RUN holds until reset. Inside ST_RUN, a step taken at the last phase wraps to phase 0 (transition RUN_WRAP, also a boundary), and any other step advances the phase by one (transition RUN_ADVANCE).

Top module: `pulse_synth`

## Requirements
- R1: After reset, `smp_out` is 0, `smp_vld` is 0, `smp_phase` is 0 and `ovf_flag` is 0.
- R2: After an isolated mark, the twelve samples of the mark's own interval equal the UI1 entries of slots 0 to 11. The next interval gives the UI2 entries and the one after that gives the UI3 entries. `smp_phase` reports the slot index 0 to 11 of each sample, in order.
- R3: A space contributes zero. Three spaces in a row give all-zero samples.
- R4: Marks alternate in polarity, and the first mark after reset is positive. A negative mark uses the negated shape, and negating -64 gives +63.
- R5: When consecutive symbols overlap, the current symbol's UI1 entry, the previous symbol's UI2 entry and the UI2-back symbol's UI3 entry are added for the same slot.
- R6: A sum above +63 is output as +63 (0x3F). A sum below -64 is output as -64 (0x40).
- R7: `ovf_flag` becomes 1 after any clipped sample and stays 1 until a cycle with `stat_rd` high, after which it is 0. If a clip happens in the same cycle as `stat_rd`, the flag stays 1. Without a clip the flag stays 0.
- R8: A write stores `cfg_data[6:0]` as a two's-complement value. `cfg_data[7]` has no effect. Writes address UI `cfg_ui` (0 to 2) and slot `cfg_slot` (0 to 13).
- R9: Slots 12 and 13 accept writes, but their contents never appear in any sample.
- R10: A shape write takes effect from the next unit-interval boundary. Samples for the rest of the current interval use the old shape.
- R11: `smp_vld` is high exactly in the cycle after a cycle with `ph_en` high. `smp_out` and `smp_phase` hold their values between updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Shape write strobe |
| cfg_ui | input | 2 | Unit interval of the entry written (0 to 2) |
| cfg_slot | input | 4 | Slot of the entry written (0 to 13) |
| cfg_data | input | 8 | Amplitude; bits 6:0 are two's complement, bit 7 is ignored |
| ph_en | input | 1 | Phase step: produce the next sample |
| sym_mark | input | 1 | Symbol taken at each interval boundary: 1 is a mark, 0 is a space |
| stat_rd | input | 1 | Status read strobe that clears the overflow flag |
| smp_out | output | 7 | Registered, saturated amplitude sample |
| smp_vld | output | 1 | Pulses one cycle after each phase step |
| smp_phase | output | 4 | Slot index of the current sample |
| ovf_flag | output | 1 | Sticky overflow (clip) indicator |

## Verification
The bench drives an entry of -64 in UI1, slot 0. A design that negates it without saturation would output -64 for a negative mark instead of +63. Mark pairs against a ±40 shape push the sum past both rails; a narrow adder would wrap to a small value, and a missing clamp would show a wrong sign. The bench rewrites the whole shape in the middle of an interval and expects the old shape until the boundary, which catches a design that writes straight into the active bank. It also issues a status read in the same cycle as a clipping step, which catches a clear that wins over a new overflow. Large values in slots 12 and 13, and writes with the top data bit set, would show up as wrong amplitudes if the design played those slots or kept that bit.

// File: rtl/psyn_pkg.sv
package psyn_pkg;

    parameter int AMP_W  = 7;
    parameter int SLOT_N = 14;
    parameter int PH_N   = 12;
    parameter int UI_N   = 3;

    typedef enum logic [1:0] {
        CF_ZERO = 2'b00,
        CF_POS  = 2'b01,
        CF_NEG  = 2'b10
    } coef_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_st_e;

endpackage

// File: rtl/ps_shape_bank.sv
module ps_shape_bank #(
    parameter int AMP_W   = psyn_pkg::AMP_W,
    parameter int SLOT_N  = psyn_pkg::SLOT_N,
    parameter int PH_N    = psyn_pkg::PH_N,
    parameter int UI_N    = psyn_pkg::UI_N,
    localparam int UI_AW  = $clog2(UI_N),
    localparam int SLOT_AW = $clog2(SLOT_N)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [UI_AW-1:0]              wr_ui,
    input  logic [SLOT_AW-1:0]            wr_slot,
    input  logic [AMP_W-1:0]              wr_amp,
    input  logic                          load_i,
    input  logic [SLOT_AW-1:0]            rd_ph,
    output logic [UI_N-1:0][AMP_W-1:0]    shp_o
);

    // Shadow bank: every slot the port can address (slots PH_N.. are kept but never played)
    logic [AMP_W-1:0] shadow_q [UI_N][SLOT_N];
    // Active bank: only the slots that are played
    logic [AMP_W-1:0] active_q [UI_N][PH_N];

    logic wr_hit;
    assign wr_hit = wr_en && (int'(wr_ui) < UI_N) && (int'(wr_slot) < SLOT_N);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int u = 0; u < UI_N; u++) begin
                for (int s = 0; s < SLOT_N; s++) shadow_q[u][s] <= '0;
            end
        end else if (wr_hit) begin
            shadow_q[wr_ui][wr_slot] <= wr_amp;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int u = 0; u < UI_N; u++) begin
                for (int p = 0; p < PH_N; p++) active_q[u][p] <= '0;
            end
        end else if (load_i) begin
            for (int u = 0; u < UI_N; u++) begin
                for (int p = 0; p < PH_N; p++) active_q[u][p] <= shadow_q[u][p];
            end
        end
    end

    // On a boundary the sample being built already uses the bank that is being loaded
    for (genvar u = 0; u < UI_N; u++) begin : g_rd
        assign shp_o[u] = load_i ? shadow_q[u][rd_ph] : active_q[u][rd_ph];
    end

    AST_RD_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> (rd_ph == '0)); // R10

endmodule

// File: rtl/ps_seq_fsm.sv
module ps_seq_fsm #(
    parameter int PH_N    = psyn_pkg::PH_N,
    parameter int UI_N    = psyn_pkg::UI_N,
    parameter int SLOT_N  = psyn_pkg::SLOT_N,
    localparam int SLOT_AW = $clog2(SLOT_N)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       step_i,
    input  logic                       mark_i,
    output logic                       boundary_o,
    output logic [SLOT_AW-1:0]         ph_use_o,
    output logic [UI_N-1:0][1:0]       coef_use_o
);
    import psyn_pkg::*;

    localparam logic [SLOT_AW-1:0] PH_LAST = SLOT_AW'(PH_N - 1);

    seq_st_e                 st_q, st_d;
    logic [SLOT_AW-1:0]      ph_q;
    logic [UI_N-1:0][1:0]    coef_q;
    logic                    pol_q;      // 1: next mark is negative
    logic [1:0]              coef_new;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Next state and boundary decode
    always_comb begin
        st_d       = st_q;
        boundary_o = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (step_i) begin
                    st_d       = ST_RUN;      // IDLE_TO_RUN
                    boundary_o = 1'b1;
                end
            end
            ST_RUN: begin
                if (step_i && (ph_q == PH_LAST)) begin
                    boundary_o = 1'b1;        // RUN_WRAP
                end
            end
        endcase
    end

    assign coef_new = !mark_i ? CF_ZERO : (pol_q ? CF_NEG : CF_POS);
    assign ph_use_o = boundary_o ? '0 : (ph_q + 1'b1);

    assign coef_use_o[0] = boundary_o ? coef_new : coef_q[0];
    for (genvar u = 1; u < UI_N; u++) begin : g_hist
        assign coef_use_o[u] = boundary_o ? coef_q[u-1] : coef_q[u];
    end

    // Phase, symbol history and polarity registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q   <= '0;
            coef_q <= '0;
            pol_q  <= 1'b0;
        end else if (step_i) begin
            ph_q   <= ph_use_o;
            coef_q <= coef_use_o;
            if (boundary_o && mark_i) pol_q <= ~pol_q;
        end
    end

    AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ph_q <= PH_LAST); // R2
    AST_AMI_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary_o && mark_i) |=> (pol_q != $past(pol_q))); // R4
    AST_SPACE_HOLD_POL: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !(boundary_o && mark_i)) |=> $stable(pol_q)); // R4

endmodule

// File: rtl/ps_sum_sat.sv
module ps_sum_sat #(
    parameter int AMP_W = psyn_pkg::AMP_W,
    parameter int UI_N  = psyn_pkg::UI_N,
    localparam int SUM_W = AMP_W + $clog2(UI_N) + 1
) (
    input  logic [UI_N-1:0][AMP_W-1:0]  shp_i,
    input  logic [UI_N-1:0][1:0]        coef_i,
    output logic signed [AMP_W-1:0]     smp_o,
    output logic                        clip_o
);
    import psyn_pkg::*;

    localparam logic signed [AMP_W-1:0] MAX_A = {1'b0, {(AMP_W-1){1'b1}}};
    localparam logic signed [AMP_W-1:0] MIN_A = {1'b1, {(AMP_W-1){1'b0}}};
    localparam logic signed [SUM_W-1:0] HI_S  = SUM_W'(MAX_A);
    localparam logic signed [SUM_W-1:0] LO_S  = SUM_W'(MIN_A);

    logic signed [SUM_W-1:0] acc;

    always_comb begin
        acc = '0;
        for (int u = 0; u < UI_N; u++) begin
            logic signed [AMP_W-1:0] t;
            t = shp_i[u];
            if (coef_i[u] == CF_NEG) t = (t == MIN_A) ? MAX_A : -t;
            if (coef_i[u] != CF_ZERO) acc = acc + SUM_W'(t);
        end
    end

    always_comb begin
        clip_o = 1'b0;
        smp_o  = acc[AMP_W-1:0];
        if (acc > HI_S) begin
            smp_o  = MAX_A;
            clip_o = 1'b1;
        end else if (acc < LO_S) begin
            smp_o  = MIN_A;
            clip_o = 1'b1;
        end
    end

endmodule

// File: rtl/pulse_synth.sv
module pulse_synth #(
    parameter int AMP_W   = psyn_pkg::AMP_W,
    parameter int SLOT_N  = psyn_pkg::SLOT_N,
    parameter int PH_N    = psyn_pkg::PH_N,
    parameter int UI_N    = psyn_pkg::UI_N,
    localparam int UI_AW  = $clog2(UI_N),
    localparam int SLOT_AW = $clog2(SLOT_N)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [UI_AW-1:0]         cfg_ui,
    input  logic [SLOT_AW-1:0]       cfg_slot,
    input  logic [AMP_W:0]           cfg_data,
    input  logic                     ph_en,
    input  logic                     sym_mark,
    input  logic                     stat_rd,
    output logic signed [AMP_W-1:0]  smp_out,
    output logic                     smp_vld,
    output logic [SLOT_AW-1:0]       smp_phase,
    output logic                     ovf_flag
);

    logic                        boundary;
    logic [SLOT_AW-1:0]          ph_use;
    logic [UI_N-1:0][1:0]        coef_use;
    logic [UI_N-1:0][AMP_W-1:0]  shp;
    logic signed [AMP_W-1:0]     sum_smp;
    logic                        clip;
    logic                        unused_msb;

    assign unused_msb = cfg_data[AMP_W];

    ps_seq_fsm #(.PH_N(PH_N), .UI_N(UI_N), .SLOT_N(SLOT_N)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_i     (ph_en),
        .mark_i     (sym_mark),
        .boundary_o (boundary),
        .ph_use_o   (ph_use),
        .coef_use_o (coef_use)
    );

    ps_shape_bank #(.AMP_W(AMP_W), .SLOT_N(SLOT_N), .PH_N(PH_N), .UI_N(UI_N)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_ui   (cfg_ui),
        .wr_slot (cfg_slot),
        .wr_amp  (cfg_data[AMP_W-1:0]),
        .load_i  (boundary),
        .rd_ph   (ph_use),
        .shp_o   (shp)
    );

    ps_sum_sat #(.AMP_W(AMP_W), .UI_N(UI_N)) u_sum (
        .shp_i  (shp),
        .coef_i (coef_use),
        .smp_o  (sum_smp),
        .clip_o (clip)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_out   <= '0;
            smp_phase <= '0;
            smp_vld   <= 1'b0;
            ovf_flag  <= 1'b0;
        end else begin
            smp_vld  <= ph_en;
            ovf_flag <= (ph_en && clip) || (ovf_flag && !stat_rd);
            if (ph_en) begin
                smp_out   <= sum_smp;
                smp_phase <= ph_use;
            end
        end
    end

    AST_VLD_AFTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ph_en |=> smp_vld); // R11
    AST_NO_VLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !ph_en |=> !smp_vld); // R11
    AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !ph_en |=> ($stable(smp_out) && $stable(smp_phase))); // R11
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !stat_rd) |=> ovf_flag); // R7
    AST_OVF_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !(ph_en && clip)) |=> !ovf_flag); // R7
    AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_en && clip) |=> ovf_flag); // R6

endmodule

// File: tb/sim_pulse_synth.sv
`timescale 1ns/1ps
module sim_pulse_synth;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [1:0]        cfg_ui = '0;
    logic [3:0]        cfg_slot = '0;
    logic [7:0]        cfg_data = '0;
    logic              ph_en = 1'b0;
    logic              sym_mark = 1'b0;
    logic              stat_rd = 1'b0;
    logic signed [6:0] smp_out;
    logic              smp_vld;
    logic [3:0]        smp_phase;
    logic              ovf_flag;

    always #2.5 clk = ~clk;

    pulse_synth u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ui(cfg_ui),
        .cfg_slot(cfg_slot), .cfg_data(cfg_data), .ph_en(ph_en),
        .sym_mark(sym_mark), .stat_rd(stat_rd), .smp_out(smp_out),
        .smp_vld(smp_vld), .smp_phase(smp_phase), .ovf_flag(ovf_flag)
    );

    typedef struct { int val; int ph; string req; } exp_t;
    exp_t q[$];

    int    total = 0;
    int    bad = 0;
    bit    done = 1'b0;
    string cur_req = "R2";

    // reference model state
    int shadow [3][14];
    int active [3][12];
    int c0 = 0, c1 = 0, c2 = 0;
    bit pol = 1'b0;
    bit started = 1'b0;
    int mph = 0;
    bit exp_ovf = 1'b0;

    task automatic chk(bit ok, string req, int got, int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s got=%0d exp=%0d", req, got, expv);
        end
    endtask

    function automatic int term(int c, int a);
        if (c == 0) return 0;
        if (c > 0)  return a;
        return (a == -64) ? 63 : -a;
    endfunction

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && smp_vld) begin
            if (q.size() == 0) begin
                chk(1'b0, "R11 unexpected sample", int'(smp_out), 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(int'(smp_out) == e.val, {e.req, " sample"}, int'(smp_out), e.val);
                chk(int'(smp_phase) == e.ph, {e.req, " phase"}, int'(smp_phase), e.ph);
            end
        end
    end

    task automatic wr(int ui, int slot, logic [7:0] d);
        int v;
        @(negedge clk);
        cfg_we = 1'b1; cfg_ui = 2'(ui); cfg_slot = 4'(slot); cfg_data = d;
        v = int'(d[6:0]);
        if (v > 63) v = v - 128;
        if (ui < 3 && slot < 14) shadow[ui][slot] = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic step(bit mark, bit rd = 1'b0);
        int s, held;
        bit clip;
        @(negedge clk);
        ph_en = 1'b1; sym_mark = mark; stat_rd = rd;
        if (!started || mph == 11) begin
            for (int u = 0; u < 3; u++)
                for (int p = 0; p < 12; p++) active[u][p] = shadow[u][p];
            c2 = c1; c1 = c0;
            if (mark) begin c0 = pol ? -1 : 1; pol = !pol; end
            else c0 = 0;
            mph = 0; started = 1'b1;
        end else begin
            mph++;
        end
        s = term(c0, active[0][mph]) + term(c1, active[1][mph]) + term(c2, active[2][mph]);
        clip = 1'b0;
        if (s > 63)  begin s = 63;  clip = 1'b1; end
        if (s < -64) begin s = -64; clip = 1'b1; end
        exp_ovf = clip | (exp_ovf & !rd);
        q.push_back('{s, mph, cur_req});
        @(negedge clk);
        ph_en = 1'b0; stat_rd = 1'b0; sym_mark = 1'b0;
        chk(smp_vld == 1'b1, "R11 vld after step", int'(smp_vld), 1);
        chk(ovf_flag == exp_ovf, "R7 flag after step", int'(ovf_flag), int'(exp_ovf));
        held = int'(smp_out);
        @(negedge clk);
        chk(smp_vld == 1'b0, "R11 vld single", int'(smp_vld), 0);
        chk(int'(smp_out) == held, "R11 hold", int'(smp_out), held);
    endtask

    task automatic ui(bit mark);
        for (int i = 0; i < 12; i++) step(mark);
    endtask

    task automatic rd_status();
        @(negedge clk);
        chk(ovf_flag == exp_ovf, "R7 before read", int'(ovf_flag), int'(exp_ovf));
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
        exp_ovf = 1'b0;
        chk(ovf_flag == 1'b0, "R7 cleared by read", int'(ovf_flag), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired got=0 exp=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int u = 0; u < 3; u++)
            for (int s = 0; s < 14; s++) shadow[u][s] = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(int'(smp_out) == 0, "R1 smp_out", int'(smp_out), 0);
        chk(smp_vld == 1'b0, "R1 smp_vld", int'(smp_vld), 0);
        chk(smp_phase == 4'd0, "R1 smp_phase", int'(smp_phase), 0);
        chk(ovf_flag == 1'b0, "R1 ovf_flag", int'(ovf_flag), 0);

        // shape A: UI1 rising with -64 at slot 0 (top bit set), UI2 falling, UI3 small (top bit set)
        wr(0, 0, 8'hC0);
        for (int p = 1; p < 12; p++) wr(0, p, 8'(3 * p + 4));
        for (int p = 0; p < 12; p++) wr(1, p, {1'b0, 7'(-p)});
        for (int p = 0; p < 12; p++) wr(2, p, {1'b1, 7'(p / 2)});
        for (int u = 0; u < 3; u++) begin
            wr(u, 12, 8'h3F);
            wr(u, 13, 8'h3F);
        end

        cur_req = "R2 R8 R9 isolated mark UI1"; ui(1'b1);
        cur_req = "R2 R9 tail UI2";             ui(1'b0);
        cur_req = "R2 R8 tail UI3";             ui(1'b0);
        cur_req = "R3 spaces only";             ui(1'b0);
        cur_req = "R4 negative mark";           ui(1'b1);
        cur_req = "R4 negative tail";           ui(1'b0);
        ui(1'b0);
        cur_req = "R5 overlap";
        ui(1'b1); ui(1'b1); ui(1'b1); ui(1'b0); ui(1'b0);
        cur_req = "R3 spaces after marks";      ui(1'b0);
        @(negedge clk);
        chk(ovf_flag == 1'b0, "R7 no clip no flag", int'(ovf_flag), 0);

        // R10: rewrite whole shape mid-interval
        cur_req = "R10 old shape kept";
        for (int i = 0; i < 5; i++) step(1'b1);
        for (int p = 0; p < 14; p++) begin
            wr(0, p, 8'h28);
            wr(1, p, 8'h58);
            wr(2, p, 8'h00);
        end
        for (int i = 0; i < 7; i++) step(1'b1);

        cur_req = "R6 R10 clamp with new shape";
        ui(1'b1); ui(1'b1); ui(1'b1);
        rd_status();

        // clip in the same cycle as a read keeps the flag
        cur_req = "R6 R7 read with clip";
        step(1'b1, 1'b1);
        @(negedge clk);
        chk(ovf_flag == 1'b1, "R7 same-cycle clip wins", int'(ovf_flag), 1);
        for (int i = 0; i < 11; i++) step(1'b1);
        cur_req = "R3 R6 spaces"; ui(1'b0); ui(1'b0);
        rd_status();
        ui(1'b0);
        @(negedge clk);
        chk(ovf_flag == 1'b0, "R7 stays clear", int'(ovf_flag), 0);

        repeat (4) @(negedge clk);
        chk(q.size() == 0, "R11 all samples seen", q.size(), 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule